// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Quad 2:1 Switch Controller

This block is the serial-bus slave that sits in front of a controller for four 2:1 signal switches. It samples the bus clock and data lines in the system clock domain, cleans them up and finds bus start and stop conditions. It answers one 7-bit address. The top four bits of that address are a fixed prefix and the low three come from strap pins. A write carries one or more two-byte words. Each word is a command byte followed by a control byte. A read returns a two-byte image of the switch state.

Toward the switch core the block gives a one-cycle strobe together with the command byte and two control flags. The first flag is the load flag, which commits the pending commands. The second flag is the active-low soft reset. The core supplies a 16-bit status word, which the block sends back on a read. The data line is driven as an open-drain enable. While that enable is high, the line is pulled low.

Top module: `mux_ctl_i2c_slave`

## Requirements
- R1: After reset, sda_oe and cmd_valid are low and no transfer is in progress.
- R2: An address byte whose upper seven bits equal 1010 followed by strap[2:0] is acknowledged: sda_oe holds the data line low through the ninth clock. The eighth bit selects the direction, with 1 meaning read and 0 meaning write.
- R3: An address that does not match gets no acknowledge. All later bytes up to the next start produce no acknowledge and no cmd_valid.
- R4: In a write, every data byte is acknowledged. The byte after the address is the command byte and the next is the control byte. When the control byte completes, cmd_valid pulses high for exactly one cycle. At that pulse, cmd_byte holds the command byte, cmd_load holds control bit 1 and cmd_reset_n holds control bit 0.
- R5: Several command/control pairs in one write transaction each produce their own cmd_valid pulse, in arrival order.
- R6: A stop after only the command byte produces no cmd_valid. A repeated start in the middle of a byte discards the partial byte and restarts address framing.
- R7: In a read, the block shifts out status[15:8] and then status[7:0], MSB first. The word is captured when the address byte completes, so changes to status during the read do not affect the bytes sent.
- R8: A master NACK in the acknowledge slot after a read byte ends the transfer: sda_oe stays low for any further clocks until the next start. After the second byte the transfer also ends.
- R9: sda_oe changes only while SCL is low. A stop condition releases sda_oe.
- R10: A pulse on SCL shorter than three system clocks after synchronization is ignored and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| strap | input | 3 | Low three address bits |
| status | input | 16 | Switch status image from the core |
| sda_oe | output | 1 | High pulls the data line low |
| cmd_valid | output | 1 | One-cycle strobe for a completed command word |
| cmd_byte | output | 8 | Command byte of the word |
| cmd_load | output | 1 | Load flag (control bit 1) |
| cmd_reset_n | output | 1 | Active-low soft reset flag (control bit 0) |

## Verification
The hardest state to reach from the ports is a repeated start in the middle of a data byte. It needs a master model that can break off a bit sequence with SDA falling while SCL is high, and then proves that no stale bits leak into the next word. The bench drives the wired-AND bus itself. It runs a transfer that sends half a byte, issues a repeated start, and then sends a fresh address and command pair whose strobe contents it compares exactly. A second hard case is the sub-filter SCL glitch. The bench inserts a single-clock SCL pulse in the low phase of a bit and checks that the decoded command byte is unchanged.

// File: rtl/mux_ctl_i2c_slave.sv
module mux_ctl_i2c_slave #(
  parameter logic [3:0] ADDR_PREFIX = 4'b1010,
  parameter int         SYNC_LEN    = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         STAT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap,
  input  logic [STAT_W-1:0] status,
  output logic              sda_oe,
  output logic              cmd_valid,
  output logic [7:0]        cmd_byte,
  output logic              cmd_load,
  output logic              cmd_reset_n
);

  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK, S_IGN} state_t;

  logic [SYNC_LEN-1:0] scl_s, sda_s;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_LEN-2:0], scl_i};
      sda_s <= {sda_s[SYNC_LEN-2:0], sda_i};
      scl_h <= {scl_h[FILT_LEN-2:0], scl_s[SYNC_LEN-1]};
      sda_h <= {sda_h[FILT_LEN-2:0], sda_s[SYNC_LEN-1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_p;
  wire scl_fall = ~scl_f & scl_p;
  wire start_c  = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_c   = scl_f & scl_p & ~sda_p & sda_f;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        sh, tx, cmd_q;
  logic [STAT_W-1:0] snap;
  logic              rd, second, nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; cmd_q <= '0;
      snap <= '0; rd <= 1'b0; second <= 1'b0; nack <= 1'b0;
      sda_oe <= 1'b0; cmd_valid <= 1'b0;
      cmd_byte <= '0; cmd_load <= 1'b0; cmd_reset_n <= 1'b1;
    end else begin
      cmd_valid <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_f}; cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              cnt <= '0;
              if (sh[7:1] == {ADDR_PREFIX, strap}) begin
                st <= S_AACK; sda_oe <= 1'b1; rd <= sh[0]; snap <= status;
              end else begin
                st <= S_IGN;
              end
            end
          S_AACK:
            if (scl_fall) begin
              cnt <= '0; second <= 1'b0;
              if (rd) begin
                st <= S_RD; tx <= snap[STAT_W-1 -: 8]; sda_oe <= ~snap[STAT_W-1];
              end else begin
                st <= S_WR; sda_oe <= 1'b0;
              end
            end
          S_WR:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_f}; cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              st <= S_WACK; sda_oe <= 1'b1;
              if (!second) cmd_q <= sh;
              else begin
                cmd_valid <= 1'b1; cmd_byte <= cmd_q;
                cmd_load <= sh[1]; cmd_reset_n <= sh[0];
              end
            end
          S_WACK:
            if (scl_fall) begin
              st <= S_WR; sda_oe <= 1'b0; cnt <= '0; second <= ~second;
            end
          S_RD:
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                st <= S_RACK; sda_oe <= 1'b0;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
              end
            end
          S_RACK:
            if (scl_rise) nack <= sda_f;
            else if (scl_fall) begin
              if (nack || second) st <= S_IGN;
              else begin
                second <= 1'b1; st <= S_RD; cnt <= '0;
                tx <= snap[7:0]; sda_oe <= ~snap[7];
              end
            end
          default: ;
        endcase
      end
    end
  end

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_valid_during_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> sda_oe);
  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> (!sda_oe && !cmd_valid));
  p_change_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && st == S_IDLE));
  p_nack_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && scl_fall && nack) |=> (st == S_IGN && !sda_oe));

endmodule

// File: tb/test_mux_ctl_i2c_slave.sv
module test_mux_ctl_i2c_slave;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [15:0] status = 16'h0000;
  logic sda_oe, cmd_valid, cmd_load, cmd_reset_n;
  logic [7:0] cmd_byte;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, n_valid = 0, r9_viol = 0;
  logic [7:0] cap_byte [0:7];
  logic [1:0] cap_ctl [0:7];
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;

  mux_ctl_i2c_slave i_mux_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap(strap),
    .status(status), .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_load(cmd_load), .cmd_reset_n(cmd_reset_n));

  always @(negedge clk) begin
    if (rst_n && cmd_valid && n_valid < 8) begin
      cap_byte[n_valid] = cmd_byte;
      cap_ctl[n_valid] = {cmd_load, cmd_reset_n};
    end
    if (rst_n && cmd_valid) n_valid++;
    if (rst_n && sda_oe != oe_prev && scl_m) r9_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    w(3); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic bit_io(input logic b, input bit glitch, output logic seen);
    w(3); sda_m = b;
    if (glitch) begin
      w(2); scl_m = 1'b1; w(1); scl_m = 1'b0;
    end
    w(Q); scl_m = 1'b1; w(Q);
    @(negedge clk); seen = sda_line;
    w(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int gbit, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], (i == gbit), s);
    bit_io(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, 1'b0, s); b[i] = s;
    end
    bit_io(nack, 1'b0, s);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 cmd_valid after reset", cmd_valid, 0);
  endtask

  task automatic t_write_single;
    logic a; int n0 = n_valid;
    bus_start;
    send_byte({4'b1010, strap, 1'b0}, -1, a); chk("R2 address ack", a, 1);
    send_byte(8'h3C, -1, a); chk("R4 command byte ack", a, 1);
    send_byte(8'h02, -1, a); chk("R4 control byte ack", a, 1);
    bus_stop;
    chk("R4 one strobe", n_valid - n0, 1);
    chk("R4 cmd_byte", cap_byte[n0], 8'h3C);
    chk("R4 load=1 reset_n=0", cap_ctl[n0], 2'b10);
    chk("R9 released after stop", sda_oe, 0);
  endtask

  task automatic t_write_multi;
    logic a; int n0 = n_valid;
    strap = 3'b010;
    bus_start;
    send_byte({4'b1010, 3'b010, 1'b0}, -1, a); chk("R2 ack with new strap", a, 1);
    send_byte(8'h91, -1, a); send_byte(8'h01, -1, a);
    send_byte(8'h14, -1, a); send_byte(8'h03, -1, a);
    chk("R4 second pair control ack", a, 1);
    bus_stop;
    chk("R5 two strobes", n_valid - n0, 2);
    chk("R5 first cmd", {cap_byte[n0], 6'd0, cap_ctl[n0]}, {8'h91, 8'h01});
    chk("R5 second cmd", {cap_byte[n0+1], 6'd0, cap_ctl[n0+1]}, {8'h14, 8'h03});
  endtask

  task automatic t_wrong_addr;
    logic a; int n0 = n_valid;
    bus_start;
    send_byte({4'b1010, 3'b011, 1'b0}, -1, a); chk("R3 no ack on mismatch", a, 0);
    send_byte(8'h55, -1, a); chk("R3 data ignored no ack", a, 0);
    send_byte(8'h03, -1, a);
    bus_stop;
    chk("R3 no strobe", n_valid - n0, 0);
    bus_start;
    send_byte({4'b1011, 3'b010, 1'b0}, -1, a); chk("R3 wrong prefix no ack", a, 0);
    bus_stop;
  endtask

  task automatic t_partial;
    logic a, s; int n0 = n_valid;
    bus_start;
    send_byte({4'b1010, strap, 1'b0}, -1, a);
    send_byte(8'h77, -1, a);
    bus_stop;
    chk("R6 no strobe on half word", n_valid - n0, 0);
    bus_start;
    send_byte({4'b1010, strap, 1'b0}, -1, a);
    for (int i = 0; i < 4; i++) bit_io(1'b1, 1'b0, s);
    bus_start;
    send_byte({4'b1010, strap, 1'b0}, -1, a); chk("R6 ack after repeated start", a, 1);
    send_byte(8'hE2, -1, a); send_byte(8'h01, -1, a);
    bus_stop;
    chk("R6 one strobe after restart", n_valid - n0, 1);
    chk("R6 clean cmd byte", cap_byte[n0], 8'hE2);
  endtask

  task automatic t_glitch;
    logic a; int n0 = n_valid;
    bus_start;
    send_byte({4'b1010, strap, 1'b0}, -1, a);
    send_byte(8'hA6, 3, a); chk("R10 ack with glitch", a, 1);
    send_byte(8'h03, -1, a);
    bus_stop;
    chk("R10 cmd unchanged by glitch", cap_byte[n0], 8'hA6);
  endtask

  task automatic t_read;
    logic a; logic [7:0] b0, b1, bx;
    status = 16'hA53C;
    bus_start;
    send_byte({4'b1010, strap, 1'b1}, -1, a); chk("R2 read address ack", a, 1);
    recv_byte(1'b0, b0);
    status = 16'h0000;
    recv_byte(1'b1, b1);
    bus_stop;
    chk("R7 high status byte", b0, 8'hA5);
    chk("R7 low byte from snapshot", b1, 8'h3C);
    status = 16'h0F81;
    bus_start;
    send_byte({4'b1010, strap, 1'b1}, -1, a);
    recv_byte(1'b1, b0);
    chk("R7 high byte second read", b0, 8'h0F);
    chk("R8 released after NACK", sda_oe, 0);
    recv_byte(1'b1, bx);
    chk("R8 no drive after NACK", bx, 8'hFF);
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    w(5); rst_n = 1'b1; w(5);
    t_reset;
    t_write_single;
    t_write_multi;
    t_wrong_addr;
    t_partial;
    t_glitch;
    t_read;
    chk("R9 sda_oe changed with SCL high", r9_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule